// File: doc/BRIEF.md
# Asynchronous Serial Port with Error Status

This block is a single-channel asynchronous serial port: a transmitter and a receiver that use 8-bit data, one stop bit and an optional parity bit. It is controlled through three 16-bit registers on a simple register bus. The first is a data register, which loads the transmitter when written and returns the last received byte when read. The second is a control word that is written at the same address where a status word is read. The third is a bit-clock divisor, and every serial bit lasts divisor+1 clock cycles.

The receive input and the transmit output each have their own polarity inversion. A break control holds the transmit line at the space level. Parity, framing and overrun errors are each recorded in the status word, together with a summary flag, and one control bit clears all three. A single interrupt output combines a receive-ready term and a transmit-ready term, each with its own enable. The receiver has a one-byte holding register. The transmitter has no queue: its buffer counts as empty whenever no frame is being sent.

Register addresses are 0 for data, 1 for control/status and 2 for the divisor. Reads are combinational. A read strobe on address 0 releases the receive buffer. The reset input is asynchronous and active low, and must be deasserted synchronously to the clock.

Top module: `async_serial_port`

## Requirements
- R1: After reset, tx_o is 1, irq_o is 0, the divisor reads back its reset value 15, and with rx_i held at 1 the status word reads 0x2100.
- R2: A write to address 0 while the transmitter is idle sends a frame on the line. The frame is a start bit of 0, then the 8 data bits LSB first, then a stop bit of 1. Each bit lasts divisor+1 cycles, and the start bit appears in the cycle after the write edge. Status bit 8 (transmit buffer empty) is 0 from that edge until the stop bit ends.
- R3: When control bit 1 is set, a parity bit goes between the data and the stop bit. With control bit 0 clear this bit is the XOR of the data bits (even parity); with control bit 0 set it is the XNOR (odd parity).
- R4: Control bit 2 inverts tx_o, both the idle level and every frame bit.
- R5: While control bit 14 (break) is set, tx_o is held at 0 XOR control bit 2 whatever the transmitter is doing, and status bit 14 reads 1.
- R6: A write to address 0 while a frame is in progress is ignored. The frame on the line continues unchanged.
- R7: The receiver samples each bit at mid-bit after it detects a start bit. A completed byte appears in bits 7:0 of address 0 and sets status bit 7 (receive buffer full). A read strobe on address 0 clears status bit 7.
- R8: A parity bit that does not match the selected parity sets status bit 9. A stop bit sampled at 0 sets status bit 10, and the receiver then waits for the line to return to 1 before it looks for a new start bit.
- R9: A byte that completes while status bit 7 is set is discarded and sets status bit 11 (overrun). The byte already held stays readable.
- R10: Status bit 15 is the OR of bits 11, 10 and 9. A control write with bit 6 set clears all three.
- R11: irq_o = (control bit 5 AND receive buffer full) OR (control bit 4 AND transmit buffer empty).
- R12: Control bit 3 inverts rx_i before the receiver sees it. Status bit 13 shows the synchronized, uninverted rx_i level.
- R13: Status bits 5:0 echo control bits 5:0. A write to address 2 sets the divisor, and a read of address 2 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (address 0 read releases the receive buffer) |
| reg_addr | input | 2 | Register address: 0 data, 1 control/status, 2 divisor |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| rx_i | input | 1 | Serial receive input |
| tx_o | output | 1 | Serial transmit output |
| irq_o | output | 1 | Interrupt request |

## Verification
The transmit line changes in the cycle that follows the write edge, and after that once every divisor+1 cycles. A control change to break or polarity shows on tx_o one cycle after its write edge. The bench therefore keeps a queue of expected line levels that is filled at the write edge, and compares tx_o against it at the falling edge of every clock. Received bytes and error flags show up a sync delay plus about half a bit after the stop bit begins. The bench waits two full bit times after each frame before it reads status or data, so that it never samples inside that window. The interrupt and status bits are read at the falling edge, which is at least one cycle after the edge of the control write or read strobe that changes them.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int REG_W = 16;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  // control bit positions (decoded by software, therefore fixed)
  localparam int CB_BREAK = 14;
  localparam int CB_CLR   = 6;
  localparam int CB_RXIE  = 5;
  localparam int CB_TXIE  = 4;
  localparam int CB_RXINV = 3;
  localparam int CB_TXINV = 2;
  localparam int CB_PAREN = 1;
  localparam int CB_ODD   = 0;

  typedef struct packed {
    logic brk;
    logic rxie;
    logic txie;
    logic rxinv;
    logic txinv;
    logic paren;
    logic odd;
  } ctrl_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] s_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) s_q[0] <= RST_VAL;
          else        s_q[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) s_q[i] <= RST_VAL;
          else        s_q[i] <= s_q[i-1];
      end
    end
  endgenerate

  assign q = s_q[STAGES-1];
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              paren,
  input  logic              odd,
  input  logic [DIV_W-1:0]  div,
  input  logic              brk,
  input  logic              txinv,
  output logic              busy,
  output logic              tx_o
);
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_PAR  = IDX_W'(DATA_W + 2);
  localparam logic [IDX_W-1:0] LAST_NPAR = IDX_W'(DATA_W + 1);

  logic [FRAME_MAX-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]     idx_q, idx_d, last_q, last_d;
  logic [DIV_W-1:0]     cnt_q, cnt_d;
  logic                 busy_q, busy_d;
  logic                 par_bit, line;

  assign par_bit = (^din) ^ odd;

  always_comb begin
    frame_d = frame_q;
    idx_d   = idx_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    if (!busy_q) begin
      if (load) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        cnt_d   = div;
        frame_d = paren ? {1'b1, par_bit, din, 1'b0} : {2'b11, din, 1'b0};
        last_d  = paren ? LAST_PAR : LAST_NPAR;
      end
    end else if (cnt_q == '0) begin
      if (idx_q == last_q) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
        cnt_d = div;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      idx_q   <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign line = busy_q ? frame_q[idx_q] : 1'b1;
  assign tx_o = (brk ? 1'b0 : line) ^ txinv;
  assign busy = busy_q;
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_l,
  input  logic [DIV_W-1:0]  div,
  input  logic              paren,
  input  logic              odd,
  input  logic              rd_ack,
  input  logic              clr_err,
  output logic [DATA_W-1:0] data_o,
  output logic              rbf_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              oe_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic              pbad_q, pbad_d;
  logic              rbf_q, rbf_d, pe_q, pe_d, fe_q, fe_d, oe_q, oe_d;
  logic              commit, ferr;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pbad_d = pbad_q;
    commit = 1'b0;
    ferr   = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (!rx_l) begin
          st_d  = RX_START;
          cnt_d = div >> 1;
        end
      end
      RX_START: begin
        if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else if (!rx_l) begin
          st_d   = RX_DATA;
          cnt_d  = div;
          idx_d  = '0;
          pbad_d = 1'b0;
        end else st_d = RX_IDLE;
      end
      RX_DATA: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          sh_d  = {rx_l, sh_q[DATA_W-1:1]};
          cnt_d = div;
          if (idx_q == IDX_LAST) st_d = paren ? RX_PAR : RX_STOP;
          else                   idx_d = idx_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          pbad_d = rx_l ^ (^sh_q) ^ odd;
          cnt_d  = div;
          st_d   = RX_STOP;
        end
      end
      RX_STOP: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          commit = 1'b1;
          ferr   = !rx_l;
          st_d   = rx_l ? RX_IDLE : RX_HOLD;
        end
      end
      RX_HOLD: begin
        if (rx_l) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_comb begin
    data_d = data_q;
    rbf_d  = rbf_q & ~rd_ack;
    oe_d   = oe_q & ~clr_err;
    fe_d   = fe_q & ~clr_err;
    pe_d   = pe_q & ~clr_err;
    if (commit) begin
      if (rbf_q) oe_d = 1'b1;
      else begin
        data_d = sh_q;
        rbf_d  = 1'b1;
      end
      if (ferr)   fe_d = 1'b1;
      if (pbad_q) pe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbad_q <= 1'b0;
      data_q <= '0;
      rbf_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pbad_q <= pbad_d;
      data_q <= data_d;
      rbf_q  <= rbf_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
    end
  end

  assign data_o = data_q;
  assign rbf_o  = rbf_q;
  assign pe_o   = pe_q;
  assign fe_o   = fe_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          DIV_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] DIV_RESET   = 16'd15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        irq_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              wr_data, wr_ctrl, wr_div, rd_data, clr_err;
  logic              tx_busy, rx_s, rx_l;
  logic [DATA_W-1:0] rx_data;
  logic              rx_rbf, rx_pe, rx_fe, rx_oe;
  logic [REG_W-1:0]  status;

  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
  assign clr_err = wr_ctrl && reg_wdata[CB_CLR];

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (wr_ctrl) begin
      ctrl_d.brk   = reg_wdata[CB_BREAK];
      ctrl_d.rxie  = reg_wdata[CB_RXIE];
      ctrl_d.txie  = reg_wdata[CB_TXIE];
      ctrl_d.rxinv = reg_wdata[CB_RXINV];
      ctrl_d.txinv = reg_wdata[CB_TXINV];
      ctrl_d.paren = reg_wdata[CB_PAREN];
      ctrl_d.odd   = reg_wdata[CB_ODD];
    end
    if (wr_div) div_d = reg_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
    end
  end

  asp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
  );

  assign rx_l = rx_s ^ ctrl_q.rxinv;

  asp_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .din(reg_wdata[DATA_W-1:0]),
    .paren(ctrl_q.paren), .odd(ctrl_q.odd), .div(div_q), .brk(ctrl_q.brk),
    .txinv(ctrl_q.txinv), .busy(tx_busy), .tx_o(tx_o)
  );

  asp_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .rx_l(rx_l), .div(div_q),
    .paren(ctrl_q.paren), .odd(ctrl_q.odd), .rd_ack(rd_data), .clr_err(clr_err),
    .data_o(rx_data), .rbf_o(rx_rbf), .pe_o(rx_pe), .fe_o(rx_fe), .oe_o(rx_oe)
  );

  always_comb begin
    status     = '0;
    status[15] = rx_pe | rx_fe | rx_oe;
    status[14] = ctrl_q.brk;
    status[13] = rx_s;
    status[11] = rx_oe;
    status[10] = rx_fe;
    status[9]  = rx_pe;
    status[8]  = !tx_busy;
    status[7]  = rx_rbf;
    status[5]  = ctrl_q.rxie;
    status[4]  = ctrl_q.txie;
    status[3]  = ctrl_q.rxinv;
    status[2]  = ctrl_q.txinv;
    status[1]  = ctrl_q.paren;
    status[0]  = ctrl_q.odd;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = REG_W'(rx_data);
      ADDR_CTRL: reg_rdata = status;
      ADDR_DIV:  reg_rdata = REG_W'(div_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_o = (ctrl_q.rxie & rx_rbf) | (ctrl_q.txie & ~tx_busy);
endmodule

// File: rtl/asp_chk.sv
module asp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       clr_bit,
  input logic       tx_o,
  input logic       tx_busy,
  input logic       brk,
  input logic       txinv,
  input logic       rxie,
  input logic       rbf,
  input logic       oe,
  input logic       irq_o
);
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !brk) |-> (tx_o == !txinv));

  a_r2_frame_starts_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(reg_wr && reg_addr == 2'd0));

  a_r5_break_space: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (tx_o == txinv));

  a_r7_rbf_released_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rbf) |-> $past(reg_rd && reg_addr == 2'd0));

  a_r9_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(rbf));

  a_r10_overrun_cleared_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(reg_wr && reg_addr == 2'd1 && clr_bit));

  a_r11_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rxie && rbf) |-> irq_o);
endmodule

bind async_serial_port asp_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .clr_bit(reg_wdata[6]), .tx_o(tx_o), .tx_busy(tx_busy), .brk(ctrl_q.brk),
  .txinv(ctrl_q.txinv), .rxie(ctrl_q.rxie), .rbf(rx_rbf), .oe(rx_oe), .irq_o(irq_o)
);

// File: tb/test_async_serial_port.sv
module test_async_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        rx_i = 1'b1;
  logic        tx_o, irq_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  async_serial_port i_async_serial_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_i(rx_i), .tx_o(tx_o), .irq_o(irq_o)
  );

  // behavioural line model
  bit q_line[$];
  bit m_line = 1'b1, m_brk = 1'b0, m_txinv = 1'b0, m_paren = 1'b0, m_odd = 1'b0;
  int m_div = 15;
  bit rxinv = 1'b0;

  task automatic push_bit(bit b);
    for (int k = 0; k <= m_div; k++) q_line.push_back(b);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_line.delete();
      m_line = 1'b1; m_brk = 1'b0; m_txinv = 1'b0; m_paren = 1'b0; m_odd = 1'b0; m_div = 15;
    end else begin
      if (reg_wr && reg_addr == 2'd0 && q_line.size() == 0) begin
        push_bit(1'b0);
        for (int i = 0; i < 8; i++) push_bit(reg_wdata[i]);
        if (m_paren) push_bit((^reg_wdata[7:0]) ^ m_odd);
        push_bit(1'b1);
      end
      if (reg_wr && reg_addr == 2'd1) begin
        m_brk = reg_wdata[14]; m_txinv = reg_wdata[2];
        m_paren = reg_wdata[1]; m_odd = reg_wdata[0];
      end
      if (reg_wr && reg_addr == 2'd2) m_div = int'(reg_wdata);
      m_line = (q_line.size() > 0) ? q_line.pop_front() : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp;
      exp = (m_brk ? 1'b0 : m_line) ^ m_txinv;
      checks++;
      if (tx_o !== exp) begin
        fails++;
        $display("FAIL %s tx_o line: actual=%b expected=%b at %0t", cur_req, tx_o, exp, $time);
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  // control write with a simultaneous rx_i level change
  task automatic wr_ctrl_rx(logic [15:0] d, logic rxlvl);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = d; rx_i = rxlvl;
    rxinv = d[3];
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(posedge clk); #1 reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic put_bit(bit b);
    #1 rx_i = b ^ rxinv;
    repeat (m_div + 1) @(posedge clk);
  endtask

  task automatic rx_frame(logic [7:0] b, bit with_par, bit pbit, bit stopb);
    @(posedge clk);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
    if (with_par) put_bit(pbit);
    put_bit(stopb);
    put_bit(1'b1);
    put_bit(1'b1);
  endtask

  task automatic wait_tx();
    repeat (12 * (m_div + 1) + 4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    cur_req = "R1";
    peek(2'd1, v); check("R1 status", v, 16'h2100);
    check("R1 tx_o", {15'd0, tx_o}, 16'd1);
    check("R1 irq_o", {15'd0, irq_o}, 16'd0);
    peek(2'd2, v); check("R1 divisor", v, 16'd15);

    // R13 divisor readback
    cur_req = "R13";
    wr(2'd2, 16'd7);
    peek(2'd2, v); check("R13 divisor", v, 16'd7);

    // R2 plain frame
    cur_req = "R2";
    wr(2'd0, 16'h00A5);
    repeat (5) @(posedge clk);
    peek(2'd1, v); check("R2 tbe busy", {15'd0, v[8]}, 16'd0);
    wait_tx();
    peek(2'd1, v); check("R2 tbe idle", {15'd0, v[8]}, 16'd1);

    // R3 even then odd parity
    cur_req = "R3";
    wr(2'd1, 16'h0002); wr(2'd0, 16'h003C); wait_tx();
    wr(2'd1, 16'h0003); wr(2'd0, 16'h0001); wait_tx();
    wr(2'd0, 16'h00F7); wait_tx();

    // R4 output inversion
    cur_req = "R4";
    wr(2'd1, 16'h0004);
    repeat (3) @(posedge clk);
    #1 check("R4 idle inverted", {15'd0, tx_o}, 16'd0);
    wr(2'd0, 16'h005A); wait_tx();

    // R5 break
    cur_req = "R5";
    wr(2'd1, 16'h4004);
    peek(2'd1, v); check("R5 break status", {15'd0, v[14]}, 16'd1);
    check("R5 break inverted", {15'd0, tx_o}, 16'd1);
    wr(2'd1, 16'h4000);
    wr(2'd0, 16'h0033);
    repeat (20) @(posedge clk);
    #1 check("R5 break plain", {15'd0, tx_o}, 16'd0);
    wait_tx();
    wr(2'd1, 16'h0000);

    // R6 write during a frame is ignored
    cur_req = "R6";
    wr(2'd0, 16'h000F);
    repeat (30) @(posedge clk);
    wr(2'd0, 16'h00FF);
    wait_tx();
    repeat (4) @(posedge clk);
    #1 check("R6 line idle after one frame", {15'd0, tx_o}, 16'd1);

    // R7 receive and release
    cur_req = "R7";
    rx_frame(8'h96, 1'b0, 1'b0, 1'b1);
    peek(2'd1, v); check("R7 rbf set", {15'd0, v[7]}, 16'd1);
    rd(2'd0, v);   check("R7 data", v, 16'h0096);
    peek(2'd1, v); check("R7 rbf cleared", {15'd0, v[7]}, 16'd0);

    // R11 interrupt terms
    cur_req = "R11";
    wr(2'd1, 16'h0010);
    #1 check("R11 tx term", {15'd0, irq_o}, 16'd1);
    wr(2'd1, 16'h0020);
    #1 check("R11 rx term empty", {15'd0, irq_o}, 16'd0);
    rx_frame(8'h3A, 1'b0, 1'b0, 1'b1);
    #1 check("R11 rx term full", {15'd0, irq_o}, 16'd1);
    rd(2'd0, v); check("R11 data", v, 16'h003A);
    #1 check("R11 rx term released", {15'd0, irq_o}, 16'd0);

    // R8 parity error then R10 clear
    cur_req = "R8";
    wr(2'd1, 16'h0002);
    rx_frame(8'h07, 1'b1, 1'b0, 1'b1);
    peek(2'd1, v); check("R8 parity error", {v[15], v[11:9]}, 16'h0009);
    rd(2'd0, v);   check("R8 data kept", v, 16'h0007);
    cur_req = "R10";
    wr(2'd1, 16'h0042);
    peek(2'd1, v); check("R10 clear", {v[15], v[11:9]}, 16'h0000);
    wr(2'd1, 16'h0003);
    rx_frame(8'h07, 1'b1, 1'b0, 1'b1);
    peek(2'd1, v); check("R3 odd parity ok", {v[15], v[11:9]}, 16'h0000);
    rd(2'd0, v);

    // R8 framing error
    cur_req = "R8";
    wr(2'd1, 16'h0000);
    rx_frame(8'h55, 1'b0, 1'b0, 1'b0);
    peek(2'd1, v); check("R8 framing error", {v[15], v[11:9]}, 16'h000A);
    rd(2'd0, v);   check("R8 framing data", v, 16'h0055);
    wr(2'd1, 16'h0040);

    // R9 overrun
    cur_req = "R9";
    rx_frame(8'h11, 1'b0, 1'b0, 1'b1);
    rx_frame(8'h22, 1'b0, 1'b0, 1'b1);
    peek(2'd1, v); check("R9 overrun", {v[15], v[11:9]}, 16'h000C);
    rd(2'd0, v);   check("R9 first byte kept", v, 16'h0011);
    wr(2'd1, 16'h0040);
    peek(2'd1, v); check("R10 overrun cleared", {v[15], v[11:9]}, 16'h0000);

    // R12 input inversion
    cur_req = "R12";
    wr_ctrl_rx(16'h0008, 1'b0);
    repeat (20) @(posedge clk);
    rx_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    peek(2'd1, v); check("R12 raw level", {15'd0, v[13]}, 16'd0);
    rd(2'd0, v);   check("R12 data", v, 16'h00C3);

    // R13 control echo
    cur_req = "R13";
    wr_ctrl_rx(16'h003F, 1'b0);
    peek(2'd1, v); check("R13 echo", {10'd0, v[5:0]}, 16'h003F);
    wr_ctrl_rx(16'h0000, 1'b1);
    repeat (20) @(posedge clk);
    peek(2'd1, v); check("R13 echo cleared", v, 16'h2100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule